// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a processor may touch an I/O port of one, two or four bytes. A request carries the port number, the access width, the current privilege level, the two bits of the I/O privilege field, the virtual-8086 flag and the descriptor of the active task segment: base, limit and type. A privileged request outside virtual-8086 mode is granted at once. Any other request is checked against a per-port bitmap that lives in the task segment. The checker reads the bitmap pointer and one or two bitmap bytes through a simple read port.

Each accepted request ends in a single-cycle result pulse that says either allow or fault (general protection). The port access itself is left to the requester.

Top module: `io_perm_check`

## Requirements
- R1: When `v86_i` is 0 and `cpl_i` is at most the I/O privilege level, an accepted request reports allow in the cycle after `start_i` is sampled, and no memory read is issued.
- R2: The I/O privilege level is `{iopl_hi_i, iopl_lo_i}`. With `v86_i` set, the bypass never applies, whatever the privilege levels are.
- R3: A request that is not bypassed faults in the cycle after `start_i`, with no memory read, if `tss_limit_i` is below 0x67 or if `tss_type_i & 4'hD` is not 9.
- R4: The 16-bit bitmap pointer is read at `tss_base_i + 0x66`. `mem_rdata_i[7:0]` is its low byte and `mem_rdata_i[15:8]` its high byte.
- R5: The bitmap byte index is the pointer plus `port_i >> 3`. If the index exceeds `tss_limit_i`, the request faults without any bitmap read.
- R6: The byte at `tss_base_i + index` is read from `mem_rdata_i[7:0]`. The width code in `size_i` is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. A mask of that many ones is shifted left by `port_i[2:0]`. Any set bitmap bit under the low 8 mask bits causes a fault.
- R7: When the shifted mask reaches past bit 7 and the first byte passes, the index plus 1 is checked against the limit (fault if above). The byte at `tss_base_i + index + 1` is then read and tested against the upper mask bits.
- R8: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen, and it is never high in a cycle where `done_o` is high.
- R9: After reset `done_o`, `allow_o`, `fault_o` and `mem_req_o` are 0. Each request gives one `done_o` pulse together with exactly one of `allow_o` or `fault_o`, and neither of them is ever high without `done_o`.
- R10: `start_i` is ignored while a request is in progress. The result and the read sequence follow the inputs captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| port_i | input | 16 | I/O port number |
| size_i | input | 2 | Width code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| cpl_i | input | 2 | Current privilege level |
| iopl_lo_i | input | 1 | Low bit of the I/O privilege level |
| iopl_hi_i | input | 1 | High bit of the I/O privilege level |
| v86_i | input | 1 | Virtual-8086 mode flag |
| tss_base_i | input | 32 | Task segment base address |
| tss_limit_i | input | 32 | Task segment limit |
| tss_type_i | input | 4 | Task segment type field |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_valid_i | input | 1 | Read data valid, one cycle |
| mem_rdata_i | input | 16 | Read data, byte at address in bits 7:0 |
| done_o | output | 1 | Result pulse |
| allow_o | output | 1 | Access granted (with done) |
| fault_o | output | 1 | General-protection fault (with done) |

## Verification
The privilege bypass is tried with an unusable task segment, so any grant can only come from the bypass. Asymmetric privilege-bit values separate the two bits of the field from each other, and the virtual-8086 flag is shown to override the bypass. Pointer values with distinct high and low bytes expose byte-order errors through the address of the next read. Ports at bit offsets 0, 1, 4, 5 and 7 with widths of 1, 2 and 4 bytes separate single-byte from crossing lookups. Limits exactly at the index and one below it separate the two limit checks. A random run with varying memory latency compares every read address and every result with a behavioural model.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    SZ_1B  = 2'd0,
    SZ_2B  = 2'd1,
    SZ_4B  = 2'd2,
    SZ_4BX = 2'd3
  } acc_size_e;

endpackage

// File: rtl/io_perm_screen.sv
module io_perm_screen #(
  parameter int CPL_W     = 2,
  parameter int LIMIT_W   = 32,
  parameter int TYPE_W    = 4,
  parameter logic [LIMIT_W-1:0] MIN_LIMIT = 'h67,
  parameter logic [TYPE_W-1:0]  TYPE_MASK = 'hD,
  parameter logic [TYPE_W-1:0]  TYPE_VAL  = 'h9
) (
  input  logic [CPL_W-1:0]   cpl_i,
  input  logic               iopl_lo_i,
  input  logic               iopl_hi_i,
  input  logic               v86_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [TYPE_W-1:0]  type_i,
  output logic               bypass_o,
  output logic               tss_ok_o
);
  logic [CPL_W-1:0] iopl;

  assign iopl     = CPL_W'({iopl_hi_i, iopl_lo_i});
  assign bypass_o = !v86_i && (cpl_i <= iopl);
  assign tss_ok_o = (limit_i >= MIN_LIMIT) && ((type_i & TYPE_MASK) == TYPE_VAL);
endmodule

// File: rtl/io_perm_mask.sv
module io_perm_mask
  import io_perm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int SH_W     = $clog2(BYTE_W),
  localparam int NB_W     = $clog2(MAX_BYTES + 1),
  localparam int SPAN_W   = 2 * BYTE_W
) (
  input  logic [SH_W-1:0]   bit_ofs_i,
  input  acc_size_e         size_i,
  output logic [BYTE_W-1:0] lo_mask_o,
  output logic [BYTE_W-1:0] hi_mask_o,
  output logic              spans_o
);
  logic [NB_W-1:0]      nbytes;
  logic [MAX_BYTES-1:0] width_mask;
  logic [SPAN_W-1:0]    span;

  always_comb begin
    unique case (size_i)
      SZ_1B:   nbytes = NB_W'(1);
      SZ_2B:   nbytes = NB_W'(2);
      default: nbytes = NB_W'(MAX_BYTES);
    endcase
  end

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_wmask
    assign width_mask[k] = (NB_W'(k) < nbytes);
  end

  assign span      = SPAN_W'(width_mask) << bit_ofs_i;
  assign lo_mask_o = span[BYTE_W-1:0];
  assign hi_mask_o = span[SPAN_W-1:BYTE_W];
  assign spans_o   = |hi_mask_o;
endmodule

// File: rtl/io_perm_seq.sv
module io_perm_seq
  import io_perm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 32,
  parameter int OFS_W   = 16,
  parameter int IDX_W   = 18,
  parameter int BYTE_W  = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS = 'h66
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               bypass_i,
  input  logic               tss_ok_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [IDX_W-1:0]   byte_sel_i,
  input  logic [BYTE_W-1:0]  lo_mask_i,
  input  logic [BYTE_W-1:0]  hi_mask_i,
  input  logic               spans_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [OFS_W-1:0]   mem_rdata_i,
  output logic               done_o,
  output logic               allow_o,
  output logic               fault_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_sum;
  logic [IDX_W-1:0] idx_inc;
  logic             sum_over;
  logic             inc_over;
  logic             hit_lo;
  logic             hit_hi;

  assign idx_sum  = IDX_W'(mem_rdata_i) + byte_sel_i;
  assign idx_inc  = idx_q + IDX_W'(1);
  assign sum_over = LIMIT_W'(idx_sum) > limit_i;
  assign inc_over = LIMIT_W'(idx_inc) > limit_i;
  assign hit_lo   = |(mem_rdata_i[BYTE_W-1:0] & lo_mask_i);
  assign hit_hi   = |(mem_rdata_i[BYTE_W-1:0] & hi_mask_i);

  assign busy_o    = (st_q != ST_IDLE);
  assign mem_req_o = busy_o;

  always_comb begin
    unique case (st_q)
      ST_PTR:  mem_addr_o = base_i + PTR_OFS;
      ST_LO,
      ST_HI:   mem_addr_o = base_i + ADDR_W'(idx_q);
      default: mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      done_o  <= 1'b0;
      allow_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      allow_o <= 1'b0;
      fault_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go_i) begin
            if (bypass_i) begin
              done_o  <= 1'b1;
              allow_o <= 1'b1;
            end else if (!tss_ok_i) begin
              done_o  <= 1'b1;
              fault_o <= 1'b1;
            end else begin
              st_q <= ST_PTR;
            end
          end
        end
        ST_PTR: begin
          if (mem_valid_i) begin
            if (sum_over) begin
              done_o  <= 1'b1;
              fault_o <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              idx_q <= idx_sum;
              st_q  <= ST_LO;
            end
          end
        end
        ST_LO: begin
          if (mem_valid_i) begin
            if (hit_lo || (spans_i && inc_over)) begin
              done_o  <= 1'b1;
              fault_o <= 1'b1;
              st_q    <= ST_IDLE;
            end else if (!spans_i) begin
              done_o  <= 1'b1;
              allow_o <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              idx_q <= idx_inc;
              st_q  <= ST_HI;
            end
          end
        end
        ST_HI: begin
          if (mem_valid_i) begin
            done_o  <= 1'b1;
            allow_o <= !hit_hi;
            fault_o <= hit_hi;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import io_perm_pkg::*;
#(
  parameter int PORT_W    = 16,
  parameter int CPL_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int LIMIT_W   = 32,
  parameter int TYPE_W    = 4,
  parameter int OFS_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter logic [LIMIT_W-1:0] MIN_LIMIT = 'h67,
  parameter logic [ADDR_W-1:0]  PTR_OFS   = 'h66,
  localparam int SH_W  = $clog2(BYTE_W),
  localparam int SEL_W = PORT_W - SH_W,
  localparam int IDX_W = ((OFS_W > SEL_W) ? OFS_W : SEL_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic [1:0]         size_i,
  input  logic [CPL_W-1:0]   cpl_i,
  input  logic               iopl_lo_i,
  input  logic               iopl_hi_i,
  input  logic               v86_i,
  input  logic [ADDR_W-1:0]  tss_base_i,
  input  logic [LIMIT_W-1:0] tss_limit_i,
  input  logic [TYPE_W-1:0]  tss_type_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [OFS_W-1:0]   mem_rdata_i,
  output logic               done_o,
  output logic               allow_o,
  output logic               fault_o
);
  logic               busy;
  logic               go;
  logic               bypass;
  logic               tss_ok;
  logic [PORT_W-1:0]  port_q;
  acc_size_e          size_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [BYTE_W-1:0]  lo_mask;
  logic [BYTE_W-1:0]  hi_mask;
  logic               spans;
  logic [IDX_W-1:0]   byte_sel;

  assign go       = start_i && !busy;
  assign byte_sel = IDX_W'(port_q[PORT_W-1:SH_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q  <= '0;
      size_q  <= SZ_1B;
      base_q  <= '0;
      limit_q <= '0;
    end else if (go) begin
      port_q  <= port_i;
      size_q  <= acc_size_e'(size_i);
      base_q  <= tss_base_i;
      limit_q <= tss_limit_i;
    end
  end

  io_perm_screen #(
    .CPL_W    (CPL_W),
    .LIMIT_W  (LIMIT_W),
    .TYPE_W   (TYPE_W),
    .MIN_LIMIT(MIN_LIMIT)
  ) u_screen (
    .cpl_i    (cpl_i),
    .iopl_lo_i(iopl_lo_i),
    .iopl_hi_i(iopl_hi_i),
    .v86_i    (v86_i),
    .limit_i  (tss_limit_i),
    .type_i   (tss_type_i),
    .bypass_o (bypass),
    .tss_ok_o (tss_ok)
  );

  io_perm_mask #(
    .BYTE_W   (BYTE_W),
    .MAX_BYTES(MAX_BYTES)
  ) u_mask (
    .bit_ofs_i(port_q[SH_W-1:0]),
    .size_i   (size_q),
    .lo_mask_o(lo_mask),
    .hi_mask_o(hi_mask),
    .spans_o  (spans)
  );

  io_perm_seq #(
    .ADDR_W (ADDR_W),
    .LIMIT_W(LIMIT_W),
    .OFS_W  (OFS_W),
    .IDX_W  (IDX_W),
    .BYTE_W (BYTE_W),
    .PTR_OFS(PTR_OFS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .bypass_i   (bypass),
    .tss_ok_i   (tss_ok),
    .base_i     (base_q),
    .limit_i    (limit_q),
    .byte_sel_i (byte_sel),
    .lo_mask_i  (lo_mask),
    .hi_mask_i  (hi_mask),
    .spans_i    (spans),
    .busy_o     (busy),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i),
    .done_o     (done_o),
    .allow_o    (allow_o),
    .fault_o    (fault_o)
  );
endmodule

// File: rtl/io_perm_check_sva.sv
module io_perm_check_sva #(
  parameter int CPL_W   = 2,
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 32,
  parameter logic [LIMIT_W-1:0] MIN_LIMIT = 'h67
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_i,
  input logic [CPL_W-1:0]   cpl_i,
  input logic               iopl_lo_i,
  input logic               iopl_hi_i,
  input logic               v86_i,
  input logic [LIMIT_W-1:0] tss_limit_i,
  input logic               mem_req_i,
  input logic [ADDR_W-1:0]  mem_addr_i,
  input logic               mem_valid_i,
  input logic               done_i,
  input logic               allow_i,
  input logic               fault_i
);
  logic privileged;
  assign privileged = !v86_i && (cpl_i <= CPL_W'({iopl_hi_i, iopl_lo_i}));

  // R1
  bypass_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && privileged) |=> (done_i && allow_i && !mem_req_i));

  // R3
  short_tss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && !privileged && (tss_limit_i < MIN_LIMIT)) |=> (done_i && fault_i && !mem_req_i));

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_valid_i) |=> (mem_req_i && $stable(mem_addr_i)));

  // R8
  req_idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !mem_req_i);

  // R9
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $countones({allow_i, fault_i}) == 1);

  // R9
  verdict_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_i || fault_i) |-> done_i);
endmodule

bind io_perm_check io_perm_check_sva #(
  .CPL_W    (CPL_W),
  .ADDR_W   (ADDR_W),
  .LIMIT_W  (LIMIT_W),
  .MIN_LIMIT(MIN_LIMIT)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy),
  .cpl_i      (cpl_i),
  .iopl_lo_i  (iopl_lo_i),
  .iopl_hi_i  (iopl_hi_i),
  .v86_i      (v86_i),
  .tss_limit_i(tss_limit_i),
  .mem_req_i  (mem_req_o),
  .mem_addr_i (mem_addr_o),
  .mem_valid_i(mem_valid_i),
  .done_i     (done_o),
  .allow_i    (allow_o),
  .fault_i    (fault_o)
);

// File: tb/io_perm_check_test.sv
`timescale 1ns/1ps
module io_perm_check_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] port_i = '0;
  logic [1:0]  size_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        iopl_lo_i = 1'b0;
  logic        iopl_hi_i = 1'b0;
  logic        v86_i = 1'b0;
  logic [31:0] tss_base_i = '0;
  logic [31:0] tss_limit_i = '0;
  logic [3:0]  tss_type_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        done_o, allow_o, fault_o;

  always #2 clk = ~clk;

  io_perm_check uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .port_i(port_i), .size_i(size_i),
    .cpl_i(cpl_i), .iopl_lo_i(iopl_lo_i), .iopl_hi_i(iopl_hi_i), .v86_i(v86_i),
    .tss_base_i(tss_base_i), .tss_limit_i(tss_limit_i), .tss_type_i(tss_type_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .allow_o(allow_o), .fault_o(fault_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lat = 0;
  int wcnt = 0;
  bit pending = 0;
  bit got_done = 0;
  bit exp_allow = 0;
  string cur_tag = "";
  int unsigned exp_addr[$];
  bit [7:0] mem [int unsigned];

  function automatic bit [7:0] rd8(int unsigned a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: fills exp_addr and exp_allow
  task automatic model(bit [15:0] p, bit [1:0] sz, bit [1:0] cpl, bit lo, bit hi, bit v86,
                       int unsigned base, int unsigned lim, bit [3:0] typ);
    int unsigned ofs, idx, nb;
    bit [15:0] m;
    exp_addr.delete();
    if (!v86 && cpl <= {hi, lo}) begin exp_allow = 1; return; end
    if (lim < 32'h67 || (typ & 4'hD) != 4'h9) begin exp_allow = 0; return; end
    exp_addr.push_back(base + 32'h66);
    ofs = {rd8(base + 32'h67), rd8(base + 32'h66)};
    idx = ofs + (p >> 3);
    if (idx > lim) begin exp_allow = 0; return; end
    exp_addr.push_back(base + idx);
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = 16'((1 << nb) - 1) << p[2:0];
    if ((rd8(base + idx) & m[7:0]) != 0) begin exp_allow = 0; return; end
    if (m[15:8] == 0) begin exp_allow = 1; return; end
    if (idx + 1 > lim) begin exp_allow = 0; return; end
    exp_addr.push_back(base + idx + 1);
    exp_allow = ((rd8(base + idx + 1) & m[15:8]) == 0);
  endtask

  // monitor and memory, away from the active edge
  always @(negedge clk) begin
    int unsigned a;
    cyc++;
    if (rst_ni) begin
      if (done_o) begin
        if (!pending) check(0, "R9", "unexpected done", 1, 0);
        else begin
          check(allow_o == exp_allow && fault_o == !exp_allow, cur_tag, "verdict allow",
                allow_o, exp_allow);
          check(exp_addr.size() == 0, cur_tag, "reads left", exp_addr.size(), 0);
          pending = 0;
          got_done = 1;
        end
      end else if (allow_o || fault_o) check(0, "R9", "verdict without done", 1, 0);
      if (mem_valid_i) mem_valid_i = 1'b0;
      else if (mem_req_o) begin
        if (wcnt >= lat) begin
          wcnt = 0;
          if (exp_addr.size() == 0) check(0, cur_tag, "extra read addr", mem_addr_o, 0);
          else begin
            a = exp_addr.pop_front();
            check(mem_addr_o == a, cur_tag, "read addr", mem_addr_o, a);
          end
          mem_rdata_i = {rd8(mem_addr_o + 1), rd8(mem_addr_o)};
          mem_valid_i = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic wait_done(string tag);
    int t = 0;
    while (!got_done && t < 200) begin @(negedge clk); t++; end
    if (!got_done) check(0, tag, "no done", 0, 1);
  endtask

  task automatic access(string tag, bit [15:0] p, bit [1:0] sz, bit [1:0] cpl, bit lo, bit hi,
                        bit v86, int unsigned base, int unsigned lim, bit [3:0] typ);
    @(negedge clk);
    model(p, sz, cpl, lo, hi, v86, base, lim, typ);
    cur_tag = tag; pending = 1; got_done = 0;
    port_i = p; size_i = sz; cpl_i = cpl; iopl_lo_i = lo; iopl_hi_i = hi; v86_i = v86;
    tss_base_i = base; tss_limit_i = lim; tss_type_i = typ;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(tag);
  endtask

  localparam int unsigned B = 32'h1000;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!done_o && !allow_o && !fault_o && !mem_req_o, "R9", "reset outputs",
          {done_o, allow_o, fault_o, mem_req_o}, 0);

    mem[B + 32'h66] = 8'h68; mem[B + 32'h67] = 8'h00;
    mem[B + 32'h68 + 2] = 8'h01;
    mem[B + 32'h68 + 3] = 8'h00;
    mem[B + 32'h68 + 4] = 8'h01;

    // R1 bypass with unusable segment
    access("R1", 16'h10, 0, 0, 0, 0, 0, B, 0, 4'h0);
    access("R1", 16'h10, 2, 3, 1, 1, 0, B, 0, 4'h0);
    // R2 bit order and virtual-8086 override
    access("R2", 16'h10, 0, 2, 1, 0, 0, B, 0, 4'h9);
    access("R2", 16'h10, 0, 2, 0, 1, 0, B, 0, 4'h0);
    access("R2", 16'h11, 0, 0, 1, 1, 1, B, 0, 4'h9);
    access("R2", 16'h11, 0, 0, 1, 1, 1, B, 32'h2067, 4'h9);
    // R3 segment validation
    access("R3", 16'h11, 0, 3, 0, 0, 0, B, 32'h66, 4'h9);
    access("R3", 16'h11, 0, 3, 0, 0, 0, B, 32'h2067, 4'h3);
    access("R3", 16'h11, 0, 3, 0, 0, 0, B, 32'h2067, 4'hD);
    access("R3", 16'h11, 0, 3, 0, 0, 0, B, 32'h67, 4'hB);
    // R6 single byte
    access("R6", 16'h10, 0, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R6", 16'h11, 0, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R6", 16'h1C, 2, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R6", 16'h22, 1, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    // R7 crossing
    lat = 2;
    access("R7", 16'h17, 1, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R7", 16'h1F, 1, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R7", 16'h1D, 2, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R7", 16'h1D, 3, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R7", 16'h1F, 1, 3, 0, 0, 0, B, 32'h6B, 4'h9);
    // R5 limit on first byte
    lat = 1;
    access("R5", 16'h18, 0, 3, 0, 0, 0, B, 32'h6B, 4'h9);
    access("R5", 16'h18, 0, 3, 0, 0, 0, B, 32'h6A, 4'h9);
    // R4 pointer byte order
    mem[B + 32'h66] = 8'h20; mem[B + 32'h67] = 8'h01;
    mem[B + 32'h120] = 8'h01;
    access("R4", 16'h00, 0, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    access("R4", 16'h01, 0, 3, 0, 0, 0, B, 32'h2067, 4'h9);

    // R10 start ignored while busy
    lat = 2;
    @(negedge clk);
    model(16'h00, 0, 3, 0, 0, 0, B, 32'h2067, 4'h9);
    cur_tag = "R10"; pending = 1; got_done = 0;
    port_i = 16'h00; size_i = 0; cpl_i = 3; iopl_lo_i = 0; iopl_hi_i = 0; v86_i = 0;
    tss_base_i = B; tss_limit_i = 32'h2067; tss_type_i = 4'h9;
    start_i = 1'b1;
    @(negedge clk);
    cpl_i = 0; port_i = 16'h01; tss_base_i = 32'h5000;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R10");
    repeat (4) @(negedge clk);

    // R8 random run against the model, varying latency and base
    mem[B + 32'h66] = 8'h68; mem[B + 32'h67] = 8'h00;
    for (int i = 0; i < 128; i++) mem[B + 32'h68 + i] = 8'($urandom);
    mem[32'h3_0066] = 8'h70; mem[32'h3_0067] = 8'h00;
    for (int i = 0; i < 128; i++) mem[32'h3_0070 + i] = 8'($urandom);
    for (int i = 0; i < 80; i++) begin
      int unsigned lim;
      lat = int'($urandom_range(0, 3));
      lim = ($urandom_range(0, 3) == 0) ? 32'h60 + $urandom_range(0, 40) : 32'h2067;
      access("R8", 16'($urandom_range(0, 1023)), 2'($urandom), 2'($urandom),
             1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
             (i % 2 == 0) ? B : 32'h3_0000, lim,
             ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'hB);
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule